// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing mode, a base register value, a 16-bit constant and an access size into the memory address of an operand. It also computes the new base register value and a write enable for the register file. Four modes are supported: plain register indirect, indexed (base plus a sign-extended constant), post-increment and pre-decrement. The two self-modifying modes move the base by the access width. A stack push is therefore a pre-decrement word access on the stack pointer, and a pop is a post-increment word access.

Every result is registered and appears one cycle after the request. The register file commits the write-back at the following edge. If a request names the register whose write-back is being presented in that same cycle, the stale value on `base_i` would otherwise be read. A small two-state controller holds the last write-back and forwards it to the address arithmetic. Its states are HOLD_NONE, with no write-back on the output, and HOLD_LIVE, with a write-back on the output. It enters HOLD_LIVE from either state on any cycle that issues a write-back. It returns to HOLD_NONE on any cycle that issues none.

Top module: `eag_top`

## Requirements
- R1: While and after reset, before any request, `out_valid_o`, `wb_en_o`, `err_o`, `ea_o`, `wb_data_o` and `wb_idx_o` are all zero.
- R2: Mode code 0 (register indirect) gives `ea_o` equal to the base value, `wb_data_o` equal to the base value, and `wb_en_o` low.
- R3: Mode code 1 (indexed) gives `ea_o` equal to the base plus `offset_i` sign-extended from 16 bits. `wb_data_o` equals the unchanged base and `wb_en_o` is low.
- R4: Mode code 2 (post-increment) gives `ea_o` equal to the base and `wb_data_o` equal to the base plus the step, with `wb_en_o` high.
- R5: Mode code 3 (pre-decrement) gives `ea_o` and `wb_data_o` both equal to the base minus the step, with `wb_en_o` high.
- R6: The step is set by `size_i`: code 0 gives 1, code 1 gives 2 and code 2 gives 4.
- R7: `size_i` code 3 on a valid request sets `err_o` and forces `wb_en_o` low in every mode. The step is then 0, so `ea_o` follows R2–R5 with a zero step and `wb_data_o` equals the base.
- R8: A cycle with `valid_i` low produces `out_valid_o`, `wb_en_o` and `err_o` all low in the next cycle, whatever the other inputs are.
- R9: Results for a request sampled at a clock edge appear on the outputs right after that edge and not before.
- R10: If `wb_en_o` is high and a new valid request carries the same `reg_idx_i` as `wb_idx_o`, the base used is `wb_data_o` and not `base_i`. With a different index, or with no write-back on the output, `base_i` is used.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Addressing mode: 0 indirect, 1 indexed, 2 post-increment, 3 pre-decrement |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 illegal |
| reg_idx_i | input | 4 | Index of the base register |
| base_i | input | 32 | Base register value from the register file |
| offset_i | input | 16 | Signed constant for indexed mode |
| out_valid_o | output | 1 | Registered results are valid |
| ea_o | output | 32 | Effective operand address |
| wb_en_o | output | 1 | Write the new base value back |
| wb_idx_o | output | 4 | Register index for the write-back |
| wb_data_o | output | 32 | New base register value |
| err_o | output | 1 | Illegal size code on the request |

## Verification
The write-back of one access and the base read of the next can fall in the same cycle. This happens when two self-modifying requests on one register are issued back to back, as in consecutive stack pushes or pops. The bench provokes it by issuing post-increment and then pre-decrement requests on the same index while holding a stale value on `base_i`. It judges the result by checking that each address continues the chain from the previous write-back. It then shows that a different index, or an intervening request with no write-back, falls back to `base_i`.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [1:0] {
        MD_IND = 2'd0,
        MD_IDX = 2'd1,
        MD_INC = 2'd2,
        MD_DEC = 2'd3
    } mode_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic {
        HOLD_NONE = 1'b0,
        HOLD_LIVE = 1'b1
    } hold_state_t;

endpackage

// File: rtl/eag_step_dec.sv
module eag_step_dec #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_i,
    output logic [AW-1:0] step_o,
    output logic          bad_o
);
    import eag_pkg::*;

    always_comb begin
        step_o = '0;
        bad_o  = 1'b0;
        unique case (size_i)
            SZ_BYTE: step_o = AW'(1);
            SZ_HALF: step_o = AW'(2);
            SZ_WORD: step_o = AW'(4);
            default: bad_o  = 1'b1;
        endcase
    end

endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] offset_i,
    input  logic [AW-1:0] step_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] next_o,
    output logic          wb_req_o
);
    import eag_pkg::*;

    localparam int EXT = AW - OW;

    logic [AW-1:0] disp;
    logic [AW-1:0] up;
    logic [AW-1:0] down;

    assign disp = {{EXT{offset_i[OW-1]}}, offset_i};
    assign up   = base_i + step_i;
    assign down = base_i - step_i;

    always_comb begin
        ea_o     = base_i;
        next_o   = base_i;
        wb_req_o = 1'b0;
        unique case (mode_t'(mode_i))
            MD_IND: begin
                ea_o = base_i;
            end
            MD_IDX: begin
                ea_o = base_i + disp;
            end
            MD_INC: begin
                ea_o     = base_i;
                next_o   = up;
                wb_req_o = 1'b1;
            end
            MD_DEC: begin
                ea_o     = down;
                next_o   = down;
                wb_req_o = 1'b1;
            end
            default: begin
                ea_o = base_i;
            end
        endcase
    end

endmodule

// File: rtl/eag_hold_fsm.sv
module eag_hold_fsm #(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_fire_i,
    input  logic [RW-1:0] wb_idx_i,
    input  logic [AW-1:0] wb_val_i,
    input  logic [RW-1:0] rd_idx_i,
    output logic          hit_o,
    output logic [AW-1:0] fwd_val_o
);
    import eag_pkg::*;

    hold_state_t   state_q, state_d;
    logic [RW-1:0] idx_q;
    logic [AW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_NONE: if (wb_fire_i)  state_d = HOLD_LIVE;
            HOLD_LIVE: if (!wb_fire_i) state_d = HOLD_NONE;
            default:   state_d = HOLD_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            val_q <= '0;
        end else if (wb_fire_i) begin
            idx_q <= wb_idx_i;
            val_q <= wb_val_i;
        end
    end

    always_comb begin
        hit_o     = 1'b0;
        fwd_val_o = val_q;
        unique case (state_q)
            HOLD_NONE: hit_o = 1'b0;
            HOLD_LIVE: hit_o = (idx_q == rd_idx_i);
            default:   hit_o = 1'b0;
        endcase
    end

    AST_LIVE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wb_fire_i) |-> state_q == HOLD_LIVE); // R10
    AST_NONE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wb_fire_i) |-> !hit_o); // R10

endmodule

// File: rtl/eag_top.sv
module eag_top #(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    size_i,
    input  logic [RW-1:0] reg_idx_i,
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] offset_i,
    output logic          out_valid_o,
    output logic [AW-1:0] ea_o,
    output logic          wb_en_o,
    output logic [RW-1:0] wb_idx_o,
    output logic [AW-1:0] wb_data_o,
    output logic          err_o
);
    import eag_pkg::*;

    logic [AW-1:0] step;
    logic          bad_size;
    logic          hit;
    logic [AW-1:0] fwd_val;
    logic [AW-1:0] eff_base;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] next_c;
    logic          wb_req;
    logic          wb_fire;

    eag_step_dec #(.AW(AW)) u_step (
        .size_i (size_i),
        .step_o (step),
        .bad_o  (bad_size)
    );

    eag_hold_fsm #(.AW(AW), .RW(RW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_fire_i (wb_fire),
        .wb_idx_i  (reg_idx_i),
        .wb_val_i  (next_c),
        .rd_idx_i  (reg_idx_i),
        .hit_o     (hit),
        .fwd_val_o (fwd_val)
    );

    assign eff_base = hit ? fwd_val : base_i;

    eag_addr_calc #(.AW(AW), .OW(OW)) u_calc (
        .mode_i   (mode_i),
        .base_i   (eff_base),
        .offset_i (offset_i),
        .step_i   (step),
        .ea_o     (ea_c),
        .next_o   (next_c),
        .wb_req_o (wb_req)
    );

    assign wb_fire = valid_i && wb_req && !bad_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            ea_o        <= '0;
            wb_en_o     <= 1'b0;
            wb_idx_o    <= '0;
            wb_data_o   <= '0;
            err_o       <= 1'b0;
        end else begin
            out_valid_o <= valid_i;
            wb_en_o     <= wb_fire;
            err_o       <= valid_i && bad_size;
            if (valid_i) begin
                ea_o      <= ea_c;
                wb_idx_o  <= reg_idx_i;
                wb_data_o <= next_c;
            end
        end
    end

    AST_ERR_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !wb_en_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> (!out_valid_o && !wb_en_o && !err_o)); // R8
    AST_DEC_ADDR_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !err_o && $past(mode_i) == MD_DEC) |-> ea_o == wb_data_o); // R5
    AST_INC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !err_o && $past(mode_i) == MD_INC) |->
        ((wb_data_o - ea_o) == AW'(1) || (wb_data_o - ea_o) == AW'(2) ||
         (wb_data_o - ea_o) == AW'(4))); // R4
    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && ($past(mode_i) == MD_IND || $past(mode_i) == MD_IDX)) |->
        !wb_en_o); // R3

endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  reg_idx_i = '0;
    logic [31:0] base_i = '0;
    logic [15:0] offset_i = '0;
    logic        out_valid_o;
    logic [31:0] ea_o;
    logic        wb_en_o;
    logic [3:0]  wb_idx_o;
    logic [31:0] wb_data_o;
    logic        err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    eag_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .mode_i      (mode_i),
        .size_i      (size_i),
        .reg_idx_i   (reg_idx_i),
        .base_i      (base_i),
        .offset_i    (offset_i),
        .out_valid_o (out_valid_o),
        .ea_o        (ea_o),
        .wb_en_o     (wb_en_o),
        .wb_idx_o    (wb_idx_o),
        .wb_data_o   (wb_data_o),
        .err_o       (err_o)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [1:0]  sz;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] ea;
        logic [31:0] nv;
        logic        we;
        logic        er;
    } vec_t;

    localparam int NV = 16;
    localparam logic [117:0] TBL [NV] = '{
        {2'd0, 2'd2, 32'h0000_1000, 16'h0010, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0}, // R2
        {2'd1, 2'd2, 32'h0000_1000, 16'h0010, 32'h0000_1010, 32'h0000_1000, 1'b0, 1'b0}, // R3
        {2'd1, 2'd0, 32'h0000_1000, 16'hFFF0, 32'h0000_0FF0, 32'h0000_1000, 1'b0, 1'b0}, // R3
        {2'd1, 2'd1, 32'h0000_0004, 16'h8000, 32'hFFFF_8004, 32'h0000_0004, 1'b0, 1'b0}, // R3 R11
        {2'd2, 2'd2, 32'h0000_2000, 16'h0000, 32'h0000_2000, 32'h0000_2004, 1'b1, 1'b0}, // R4 R6
        {2'd2, 2'd1, 32'h0000_2000, 16'h0000, 32'h0000_2000, 32'h0000_2002, 1'b1, 1'b0}, // R4 R6
        {2'd2, 2'd0, 32'h0000_2000, 16'h0000, 32'h0000_2000, 32'h0000_2001, 1'b1, 1'b0}, // R4 R6
        {2'd3, 2'd2, 32'h0000_2000, 16'h0000, 32'h0000_1FFC, 32'h0000_1FFC, 1'b1, 1'b0}, // R5 R6
        {2'd3, 2'd1, 32'h0000_2000, 16'h0000, 32'h0000_1FFE, 32'h0000_1FFE, 1'b1, 1'b0}, // R5 R6
        {2'd3, 2'd0, 32'h0000_2000, 16'h0000, 32'h0000_1FFF, 32'h0000_1FFF, 1'b1, 1'b0}, // R5 R6
        {2'd2, 2'd2, 32'hFFFF_FFFE, 16'h0000, 32'hFFFF_FFFE, 32'h0000_0002, 1'b1, 1'b0}, // R11
        {2'd3, 2'd0, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R11
        {2'd1, 2'd2, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R11
        {2'd2, 2'd3, 32'h0000_3000, 16'h0000, 32'h0000_3000, 32'h0000_3000, 1'b0, 1'b1}, // R7
        {2'd3, 2'd3, 32'h0000_3000, 16'h0000, 32'h0000_3000, 32'h0000_3000, 1'b0, 1'b1}, // R7
        {2'd1, 2'd3, 32'h0000_3000, 16'h0008, 32'h0000_3008, 32'h0000_3000, 1'b0, 1'b1}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] md, input logic [1:0] sz,
                         input logic [3:0] idx, input logic [31:0] b, input logic [15:0] off);
        valid_i   = v;
        mode_i    = md;
        size_i    = sz;
        reg_idx_i = idx;
        base_i    = b;
        offset_i  = off;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid_o), 32'd0);
        chk("R1 wb_en",     32'(wb_en_o),     32'd0);
        chk("R1 err",       32'(err_o),       32'd0);
        chk("R1 ea",        ea_o,             32'd0);
        chk("R1 wb_data",   wb_data_o,        32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({out_valid_o, wb_en_o, err_o}), 32'd0);

        // vector table, back to back, index differs each step so no forwarding
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            drive(1'b1, v.md, v.sz, 4'(i), v.base, v.off);
            @(negedge clk);
            chk($sformatf("R9 valid vec%0d", i), 32'(out_valid_o), 32'd1);
            chk($sformatf("R2-5 ea vec%0d", i), ea_o, v.ea);
            chk($sformatf("R4 R5 newval vec%0d", i), wb_data_o, v.nv);
            chk($sformatf("R7 wb_en vec%0d", i), 32'(wb_en_o), 32'(v.we));
            chk($sformatf("R7 err vec%0d", i), 32'(err_o), 32'(v.er));
            chk($sformatf("R10 wb_idx vec%0d", i), 32'(wb_idx_o), 32'(i));
        end

        // R8: strobe low with a self-modifying mode and illegal size
        drive(1'b0, 2'd2, 2'd3, 4'd1, 32'h0000_9000, 16'h0);
        @(negedge clk);
        chk("R8 out_valid", 32'(out_valid_o), 32'd0);
        chk("R8 wb_en",     32'(wb_en_o),     32'd0);
        chk("R8 err",       32'(err_o),       32'd0);

        // R9: outputs do not move before the edge
        drive(1'b1, 2'd2, 2'd2, 4'd5, 32'h0000_0100, 16'h0);
        #2;
        chk("R9 before edge", 32'(out_valid_o), 32'd0);
        @(negedge clk);
        chk("R9 after edge ea", ea_o, 32'h0000_0100);
        chk("R4 pop new sp", wb_data_o, 32'h0000_0104);

        // R10: same index back to back, stale base_i
        drive(1'b1, 2'd2, 2'd2, 4'd5, 32'h0000_0100, 16'h0);
        @(negedge clk);
        chk("R10 fwd inc ea", ea_o, 32'h0000_0104);
        chk("R10 fwd inc nv", wb_data_o, 32'h0000_0108);
        drive(1'b1, 2'd3, 2'd2, 4'd5, 32'h0000_0100, 16'h0);
        @(negedge clk);
        chk("R10 fwd push ea", ea_o, 32'h0000_0104);
        chk("R10 fwd push nv", wb_data_o, 32'h0000_0104);
        chk("R10 fwd push we", 32'(wb_en_o), 32'd1);
        // different index: no forwarding
        drive(1'b1, 2'd0, 2'd2, 4'd6, 32'h0000_0500, 16'h0);
        @(negedge clk);
        chk("R10 other idx", ea_o, 32'h0000_0500);
        // same index after a cycle with no write-back: base_i used
        drive(1'b1, 2'd0, 2'd2, 4'd5, 32'h0000_0777, 16'h0);
        @(negedge clk);
        chk("R10 no live wb", ea_o, 32'h0000_0777);
        // error request does not forward its result
        drive(1'b1, 2'd2, 2'd3, 4'd7, 32'h0000_0040, 16'h0);
        @(negedge clk);
        drive(1'b1, 2'd0, 2'd2, 4'd7, 32'h0000_0080, 16'h0);
        @(negedge clk);
        chk("R7 R10 err no fwd", ea_o, 32'h0000_0080);

        drive(1'b0, 2'd0, 2'd0, 4'd0, 32'h0, 16'h0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule